// File: doc/BRIEF.md
# Multiplexed LCD Drive Waveform Sequencer

This block produces, on every clock, a level code for each of four common electrodes and fifty segment electrodes of a passive LCD panel. A downstream analog stage turns each code into one of the bias voltages. The block advances only on a frame-timing strobe, and a frame spans twenty-four strobes. Within a frame it steps through the active commons. For each common it reads the matching display latch and picks the levels that place the full drive voltage across lit pixels and a small voltage across dark ones.

Four configuration inputs shape the waveform: duty (static, 1/2, 1/3 or 1/4), bias (1/2 or 1/3), inversion scheme (A or B) and display enable. With the A scheme, each common time slot has two halves of opposite polarity. With the B scheme, the polarity holds for a whole frame and flips on the next frame. Commons left unused at a lower duty copy active ones, and a disabled display grounds every output. The serial loader and the oscillator sit outside this block. They provide the latch contents and the strobe.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: After reset, the sequence begins in slot 0, first half, positive polarity, with frame parity 0. With the display enabled, the first output pattern selects logical common 0 at positive polarity.
- R2: A frame is 24 strobes, with N = duty+1 active commons. In the A scheme, and in static duty whatever the scheme, each half-slot lasts 12/N strobes. Polarity flips every half-slot, and the slot index advances after every second half-slot.
- R3: In the B scheme with a non-static duty, a slot lasts 24/N strobes. Polarity equals the frame parity, so it stays constant for a whole frame and flips at each frame boundary.
- R4: The level codes are 0 ground, 1 one-third, 2 one-half, 3 two-thirds and 4 full supply. At positive polarity:
  - a selected common is 4;
  - an unselected common is 1 under 1/3 bias and 2 under 1/2 bias;
  - an on segment is 0;
  - an off segment is 3 under 1/3 bias and 2 under 1/2 bias.
  At negative polarity: a selected common is 0, an unselected common is 3 (or 2), an on segment is 4, and an off segment is 1 (or 2).
- R5: Duty code 0 (static) makes all four commons copy logical common 0. Duty 1 gives commons 0,1,2,3 the logical indices 0,1,0,1. Duty 2 gives 0,1,2,1. Duty 3 drives each common from its own index. A physical common is selected when its logical index equals the current slot.
- R6: Segment s takes its on/off bit from `latch_bits[slot*50 + s]`, where 1 means on.
- R7: When `disp_on` is 0, every common and segment code is 0, and the counters keep running.
- R8: A change of the duty input restarts the sequence at the next clock edge: slot 0, first half, strobe count 0. Frame parity is kept. The new duty takes effect from that edge.
- R9: A clock without a strobe and without a duty change leaves the sequence position unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Frame-timing strobe, 24 per frame |
| duty | input | 2 | 0 static, 1 half, 2 third, 3 quarter |
| bias_half | input | 1 | 1 selects 1/2 bias, 0 selects 1/3 bias |
| wave_b | input | 1 | 1 selects the frame-inverting B scheme |
| disp_on | input | 1 | 0 grounds all outputs |
| latch_bits | input | 200 | Four 50-bit display latches, latch c at bits c*50 upward |
| com_lvl | output | 12 | Common k level code at bits 3k+2:3k |
| seg_lvl | output | 150 | Segment s level code at bits 3s+2:3s |

## Verification
The in-line assertions check, on every cycle:
- the half-slot and slot counters stay within range for the registered duty;
- the position holds without a strobe;
- a duty change restarts the sequence;
- frame parity moves only at a frame end;
- quarter duty selects exactly one common;
- half duty mirrors common pairs;
- selected commons sit at an extreme level;
- 1/3 bias never yields the half level;
- blanking grounds every output.

Only the bench's scenarios, compared against a behavioural model, can show the exact slot timing for each duty, the polarity order of the two schemes, the routing of latch bits and the exact level values.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int NUM_COM = 4;
    localparam int LVL_W   = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_GND   = 3'd0;
    localparam lvl_t LVL_THIRD = 3'd1;
    localparam lvl_t LVL_HALF  = 3'd2;
    localparam lvl_t LVL_TWO3  = 3'd3;
    localparam lvl_t LVL_FULL  = 3'd4;

    typedef enum logic [1:0] {
        DUTY_STATIC  = 2'd0,
        DUTY_HALF    = 2'd1,
        DUTY_THIRD   = 2'd2,
        DUTY_QUARTER = 2'd3
    } duty_e;

    // Logical common index that drives physical common k
    function automatic logic [1:0] com_owner(duty_e d, int k);
        logic [1:0] kk;
        kk = 2'(k);
        case (d)
            DUTY_STATIC:  return 2'd0;
            DUTY_HALF:    return {1'b0, kk[0]};
            DUTY_THIRD:   return (kk == 2'd3) ? 2'd1 : kk;
            default:      return kk;
        endcase
    endfunction

    function automatic lvl_t com_level(logic sel, logic pol, logic bias_half);
        if (sel)       return pol ? LVL_GND : LVL_FULL;
        if (bias_half) return LVL_HALF;
        return pol ? LVL_TWO3 : LVL_THIRD;
    endfunction

    function automatic lvl_t seg_level(logic on, logic pol, logic bias_half);
        if (on)        return pol ? LVL_FULL : LVL_GND;
        if (bias_half) return LVL_HALF;
        return pol ? LVL_THIRD : LVL_TWO3;
    endfunction

endpackage

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer
    import lcd_seq_pkg::*;
#(
    parameter int TICKS_PER_FRAME = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  duty_e      duty,
    input  logic       wave_b,
    output duty_e      duty_act,
    output logic [1:0] slot,
    output logic       pol
);
    localparam int SW = $clog2(TICKS_PER_FRAME);

    typedef struct packed {
        logic [SW-1:0] sub;
        logic          half;
        logic [1:0]    slot;
        logic          frame;
        duty_e         duty;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [SW-1:0] hl_q;
    logic          last_sub, frame_end;

    function automatic logic [SW-1:0] half_len(duty_e d);
        return SW'(TICKS_PER_FRAME / (2 * (int'(d) + 1)));
    endfunction

    always_comb begin
        hl_q      = half_len(st_q.duty);
        last_sub  = (st_q.sub == hl_q - SW'(1));
        frame_end = last_sub && st_q.half && (st_q.slot == st_q.duty);
        st_d      = st_q;
        if (duty != st_q.duty) begin
            st_d.duty = duty;
            st_d.sub  = '0;
            st_d.half = 1'b0;
            st_d.slot = 2'd0;
        end else if (tick) begin
            if (last_sub) begin
                st_d.sub  = '0;
                st_d.half = ~st_q.half;
                if (st_q.half) begin
                    if (st_q.slot == st_q.duty) begin
                        st_d.slot  = 2'd0;
                        st_d.frame = ~st_q.frame;
                    end else begin
                        st_d.slot = st_q.slot + 2'd1;
                    end
                end
            end else begin
                st_d.sub = st_q.sub + SW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sub: '0, half: 1'b0, slot: 2'd0, frame: 1'b0, duty: DUTY_STATIC};
        else        st_q <= st_d;
    end

    assign duty_act = st_q.duty;
    assign slot     = st_q.slot;
    assign pol      = (wave_b && st_q.duty != DUTY_STATIC) ? st_q.frame : st_q.half;

    logic [SW+3:0] pos_vec;
    assign pos_vec = {st_q.sub, st_q.half, st_q.slot, st_q.frame};

    assert_sub_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sub < hl_q);
    assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot <= st_q.duty);
    assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && duty == st_q.duty) |=> $stable(pos_vec));
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (duty != st_q.duty) |=> (st_q.sub == '0 && !st_q.half && st_q.slot == 2'd0));
    assert_frame_only_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && duty == st_q.duty && frame_end) |=> $stable(st_q.frame));

endmodule

// File: rtl/lcd_com_driver.sv
module lcd_com_driver
    import lcd_seq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  duty_e                   duty,
    input  logic [1:0]              slot,
    input  logic                    pol,
    input  logic                    bias_half,
    input  logic                    disp_on,
    output logic [NUM_COM*LVL_W-1:0] com_lvl
);
    logic [NUM_COM-1:0] sel;

    for (genvar k = 0; k < NUM_COM; k++) begin : g_com
        lvl_t lvl_k;
        always_comb begin
            sel[k] = (com_owner(duty, k) == slot);
            lvl_k  = disp_on ? com_level(sel[k], pol, bias_half) : LVL_GND;
        end
        assign com_lvl[k*LVL_W +: LVL_W] = lvl_k;

        assert_sel_extreme_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (disp_on && sel[k]) |-> (lvl_k == LVL_FULL || lvl_k == LVL_GND));
    end

    assert_quarter_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == DUTY_QUARTER) |-> $onehot(sel));
    assert_half_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == DUTY_HALF) |-> (com_lvl[2:0] == com_lvl[8:6] && com_lvl[5:3] == com_lvl[11:9]));

endmodule

// File: rtl/lcd_seg_driver.sv
module lcd_seg_driver
    import lcd_seq_pkg::*;
#(
    parameter int NUM_SEG = 50
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_COM*NUM_SEG-1:0] latch_bits,
    input  logic [1:0]                 slot,
    input  logic                       pol,
    input  logic                       bias_half,
    input  logic                       disp_on,
    output logic [NUM_SEG*LVL_W-1:0]   seg_lvl
);
    logic [NUM_SEG-1:0] row;
    logic [NUM_SEG-1:0] is_half;

    assign row = latch_bits[int'(slot)*NUM_SEG +: NUM_SEG];

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        lvl_t lvl_s;
        assign lvl_s = disp_on ? seg_level(row[s], pol, bias_half) : LVL_GND;
        assign seg_lvl[s*LVL_W +: LVL_W] = lvl_s;
        assign is_half[s] = (lvl_s == LVL_HALF);
    end

    assert_third_bias_no_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bias_half |-> (is_half == '0));

endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
    import lcd_seq_pkg::*;
#(
    parameter int NUM_SEG         = 50,
    parameter int TICKS_PER_FRAME = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [1:0]                 duty,
    input  logic                       bias_half,
    input  logic                       wave_b,
    input  logic                       disp_on,
    input  logic [NUM_COM*NUM_SEG-1:0] latch_bits,
    output logic [NUM_COM*LVL_W-1:0]   com_lvl,
    output logic [NUM_SEG*LVL_W-1:0]   seg_lvl
);
    duty_e      duty_act;
    logic [1:0] slot;
    logic       pol;

    lcd_slot_timer #(.TICKS_PER_FRAME(TICKS_PER_FRAME)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .duty     (duty_e'(duty)),
        .wave_b   (wave_b),
        .duty_act (duty_act),
        .slot     (slot),
        .pol      (pol)
    );

    lcd_com_driver com_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .duty      (duty_act),
        .slot      (slot),
        .pol       (pol),
        .bias_half (bias_half),
        .disp_on   (disp_on),
        .com_lvl   (com_lvl)
    );

    lcd_seg_driver #(.NUM_SEG(NUM_SEG)) seg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_bits (latch_bits),
        .slot       (slot),
        .pol        (pol),
        .bias_half  (bias_half),
        .disp_on    (disp_on),
        .seg_lvl    (seg_lvl)
    );

    assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |-> (com_lvl == '0 && seg_lvl == '0));

endmodule

// File: tb/lcd_mux_sequencer_tb_top.sv
module lcd_mux_sequencer_tb_top;
    localparam int NSEG = 50;
    localparam int NCOM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [1:0] duty = 2'd0;
    logic bias_half = 1'b0;
    logic wave_b = 1'b0;
    logic disp_on = 1'b0;
    logic [NCOM*NSEG-1:0] latch_bits = '0;
    logic [NCOM*3-1:0] com_lvl;
    logic [NSEG*3-1:0] seg_lvl;

    always #5 clk = ~clk;

    lcd_mux_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .duty(duty), .bias_half(bias_half),
        .wave_b(wave_b), .disp_on(disp_on), .latch_bits(latch_bits),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";
    int m_pos = 0;
    bit m_frame = 1'b0;
    int m_duty = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Behavioural reference: position in strobes since frame start
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pos = 0; m_frame = 1'b0; m_duty = 0;
        end else if (int'(duty) != m_duty) begin
            m_duty = int'(duty); m_pos = 0;                  // R8
        end else if (tick) begin
            m_pos++;
            if (m_pos == 24) begin m_pos = 0; m_frame = ~m_frame; end
        end
    end

    function automatic int sixths_to_code(int v);
        case (v)
            0: return 0;
            2: return 1;
            3: return 2;
            4: return 3;
            default: return 4;
        endcase
    endfunction

    task automatic compare();
        int n, slot, hidx, owner, v;
        bit pol, sel, on;
        logic [NCOM*3-1:0] ec;
        logic [NSEG*3-1:0] es;
        n = m_duty + 1;
        if (m_duty != 0 && wave_b) begin
            slot = m_pos / (24 / n); pol = m_frame;          // R3
        end else begin
            hidx = m_pos / (12 / n); slot = hidx / 2; pol = bit'(hidx % 2);   // R2
        end
        for (int k = 0; k < NCOM; k++) begin
            case (m_duty)                                    // R5
                0: owner = 0;
                1: owner = k % 2;
                2: owner = (k == 3) ? 1 : k;
                default: owner = k;
            endcase
            sel = (owner == slot);
            if (sel) v = pol ? 0 : 6;
            else if (bias_half) v = 3;
            else v = pol ? 4 : 2;                            // R4
            if (!disp_on) v = 0;                             // R7
            ec[k*3 +: 3] = 3'(sixths_to_code(v));
        end
        for (int s = 0; s < NSEG; s++) begin
            on = latch_bits[slot*NSEG + s];                  // R6
            if (on) v = pol ? 6 : 0;
            else if (bias_half) v = 3;
            else v = pol ? 2 : 4;
            if (!disp_on) v = 0;
            es[s*3 +: 3] = 3'(sixths_to_code(v));
        end
        n_vec++;
        if (com_lvl !== ec || seg_lvl !== es) begin
            n_bad++;
            $display("FAIL %s t=%0t com actual=%h expected=%h seg actual=%h expected=%h",
                     cur_req, $time, com_lvl, ec, seg_lvl, es);
        end
    endtask

    // mode 0: strobe every clock, 1: sparse strobes, 2: no strobes
    task automatic step(int cycles, int mode);
        repeat (cycles) begin
            @(negedge clk);
            compare();
            case (mode)
                0: tick = 1'b1;
                1: tick = (($urandom % 3) == 0);
                default: tick = 1'b0;
            endcase
        end
    endtask

    task automatic fill_latches();
        for (int i = 0; i < NCOM*NSEG; i += 32) begin
            logic [31:0] w;
            w = $urandom;
            for (int j = 0; j < 32; j++)
                if (i + j < NCOM*NSEG) latch_bits[i+j] = w[j];
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, blanked and then enabled while held in reset
        cur_req = "R1";
        step(3, 0);
        disp_on = 1'b1;
        fill_latches();
        step(3, 0);
        rst_n = 1'b1;
        tick = 1'b0;
        step(2, 0);

        // R2 R3 R4 R5 R6 across every duty, bias and scheme
        for (int d = 0; d < 4; d++) begin
            for (int b = 0; b < 2; b++) begin
                for (int w = 0; w < 2; w++) begin
                    duty = 2'(d); bias_half = b[0]; wave_b = w[0];
                    cur_req = w[0] ? "R3 R4 R5 R6" : "R2 R4 R5 R6";
                    fill_latches();
                    step(60, 0);
                    step(90, 1);
                end
            end
        end

        // R7: blanking while the sequence keeps running
        cur_req = "R7";
        disp_on = 1'b0;
        step(60, 1);
        disp_on = 1'b1;
        step(30, 0);

        // R8: duty changes mid-frame restart the sequence
        cur_req = "R8";
        wave_b = 1'b1;
        duty = 2'd3; step(10, 0);
        duty = 2'd1; step(5, 0);
        duty = 2'd2; step(1, 0);
        duty = 2'd3; step(40, 0);
        wave_b = 1'b0;
        duty = 2'd2; step(7, 0);

        // R9: no strobes holds the position
        cur_req = "R9";
        step(30, 2);
        step(20, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule